// File: doc/BRIEF.md
# Programmable Interrupt Trigger Detector

This block watches a vector of interrupt source lines and turns each one into a pending flag. Each line first passes through a two-flop synchronizer. A per-source detector then compares the synchronized value with the sample it took on the previous cycle. The sense mode chosen for that source decides which change counts as an event: level, falling edge, rising edge or both edges. A dispatcher downstream reads the pending vector and receives a one-cycle pulse whenever a new event is recorded.

A contiguous group of sources is tied to external pins. Each of these sources has a byte-wide configuration register, and its sense mode can be changed there. The remaining sources keep the mode they are given at reset. Software clears an edge-sensitive pending flag by writing zero to that flag's byte. A separate byte lets software raise a single-cycle software interrupt pulse. All register access goes through one byte write port and one combinational read port. There is no flow control: a write is taken in the cycle its strobe is high.

Top module: `irq_sense_unit`

## Requirements
- R1: After reset every pending flag is 0, `event_pulse` and `swint_pulse` are 0, and each source is rising-edge except those set in `LEVEL_MASK`, which start level-sensitive.
- R2: A change on `src_in` reaches `pending` on the third rising clock edge after it is applied, not earlier (two synchronizer stages plus the detector register).
- R3: In rising-edge mode (code 2) a 0-to-1 change sets the flag, and a 1-to-0 change leaves it unchanged.
- R4: In falling-edge mode (code 1) a 1-to-0 change sets the flag, and a 0-to-1 change leaves it unchanged.
- R5: In both-edges mode (code 3) any change of the line sets the flag.
- R6: In level mode (code 0) the flag follows the synchronized line: high sets it, low clears it on the next cycle. A write to the flag's byte has no effect.
- R7: For an edge-mode source, a write of 0x00 to byte address `n` (source n) clears its flag. A write of any nonzero value leaves the flag unchanged. If an event arrives in the same cycle as the clear, the event wins.
- R8: The pin configuration byte at address 0x40+p belongs to source `PIN_BASE`+p. Its sense mode sits in bits 3:2, and it reads back as mode<<2 with all other bits zero. The new mode takes effect from the cycle after the write.
- R9: Reading byte address `n` returns source n's pending flag in bit 0, with bits 7:1 zero.
- R10: A write to address 0x80 with bit 0 set gives `swint_pulse` high for exactly the following cycle. A write with bit 0 clear gives no pulse. Address 0x80 always reads as 0x00.
- R11: `event_pulse` is high for one cycle, in the same cycle a pending flag is newly set by an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_SRC | Raw interrupt source lines |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| pending | output | NUM_SRC | Pending flag per source |
| event_pulse | output | 1 | One-cycle pulse when any flag is set by a new event |
| swint_pulse | output | 1 | One-cycle software interrupt pulse |

## Verification
A wrong previous-sample or synchronizer value shows up on `pending` as an event that appears or is missed at the third edge after the line changes. A missed event also leaves `event_pulse` low in that same cycle. A corrupted mode register shows up at once on the `rd_data` readback of the configuration byte. It also shows up at the next line transition, as a flag set for the wrong polarity or a level flag that does not drop. A faulty clear decode leaves a flag set, or clears the wrong one, in the cycle after the write, where a read of that source's byte reveals it.

// File: rtl/irqs_pkg.sv
package irqs_pkg;
  typedef enum logic [1:0] {
    SENSE_LEVEL = 2'd0,
    SENSE_FALL  = 2'd1,
    SENSE_RISE  = 2'd2,
    SENSE_BOTH  = 2'd3
  } sense_t;

  localparam int unsigned ADDR_W     = 8;
  localparam int unsigned DATA_W     = 8;
  localparam logic [1:0]  REGION_PEND = 2'b00;
  localparam logic [1:0]  REGION_CFG  = 2'b01;
  localparam logic [7:0]  SWINT_ADDR  = 8'h80;
  localparam int unsigned MODE_LSB    = 2;
endpackage

// File: rtl/irqs_sync.sv
module irqs_sync #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] synced
);
  logic [WIDTH-1:0] stage1;
  logic [WIDTH-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= raw;
      stage2 <= stage1;
    end
  end

  assign synced = stage2;
endmodule

// File: rtl/irqs_detect.sv
module irqs_detect
  import irqs_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   line_s,
  input  sense_t mode,
  input  logic   clr_req,
  output logic   pending,
  output logic   fire
);
  logic prev;

  always_comb begin
    unique case (mode)
      SENSE_LEVEL: fire = line_s & ~prev;
      SENSE_FALL:  fire = ~line_s & prev;
      SENSE_RISE:  fire = line_s & ~prev;
      SENSE_BOTH:  fire = line_s ^ prev;
      default:     fire = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev    <= 1'b0;
      pending <= 1'b0;
    end else begin
      prev <= line_s;
      if (mode == SENSE_LEVEL) pending <= line_s;
      else if (fire)           pending <= 1'b1;
      else if (clr_req)        pending <= 1'b0;
    end
  end

  // R6: level flag mirrors the line one cycle later, whatever is written
  a_r6_level_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SENSE_LEVEL) |=> (pending == $past(line_s)));
  // R7: clear without a competing event empties an edge flag
  a_r7_edge_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != SENSE_LEVEL && clr_req && !fire) |=> !pending);
  // R3: rising transition in rising mode sets the flag
  a_r3_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SENSE_RISE && line_s && !prev) |=> pending);
  // R5: any change in both-edges mode sets the flag
  a_r5_both_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SENSE_BOTH && line_s != prev) |=> pending);
endmodule

// File: rtl/irqs_regs.sv
module irqs_regs
  import irqs_pkg::*;
#(
  parameter int unsigned    NUM_SRC    = 16,
  parameter int unsigned    PIN_BASE   = 8,
  parameter int unsigned    NUM_PINS   = 8,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic [ADDR_W-1:0]            rd_addr,
  input  logic [NUM_SRC-1:0]           pending,
  output logic [DATA_W-1:0]            rd_data,
  output logic [NUM_PINS-1:0][1:0]     pin_mode,
  output logic [NUM_SRC-1:0]           clr_vec,
  output logic                         swint_pulse
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [1:0]       w_region;
  logic [IDX_W-1:0] w_idx;
  logic [1:0]       r_region;
  logic [IDX_W-1:0] r_idx;
  logic             wr_pend_zero;
  logic             wr_cfg;

  assign w_region     = wr_addr[ADDR_W-1 -: 2];
  assign w_idx        = wr_addr[IDX_W-1:0];
  assign r_region     = rd_addr[ADDR_W-1 -: 2];
  assign r_idx        = rd_addr[IDX_W-1:0];
  assign wr_pend_zero = wr_en && (w_region == REGION_PEND) && (wr_data == '0);
  assign wr_cfg       = wr_en && (w_region == REGION_CFG);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_clr
    assign clr_vec[i] = wr_pend_zero && (w_idx == IDX_W'(i));
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam logic [1:0] RST_MODE =
      LEVEL_MASK[PIN_BASE+p] ? SENSE_LEVEL : SENSE_RISE;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               pin_mode[p] <= RST_MODE;
      else if (wr_cfg && w_idx == IDX_W'(p))    pin_mode[p] <= wr_data[MODE_LSB +: 2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) swint_pulse <= 1'b0;
    else        swint_pulse <= wr_en && (wr_addr == SWINT_ADDR) && wr_data[0];
  end

  always_comb begin
    rd_data = '0;
    if (r_region == REGION_PEND) begin
      for (int i = 0; i < NUM_SRC; i++)
        if (r_idx == IDX_W'(i)) rd_data[0] = pending[i];
    end else if (r_region == REGION_CFG) begin
      for (int p = 0; p < NUM_PINS; p++)
        if (r_idx == IDX_W'(p)) rd_data[MODE_LSB +: 2] = pin_mode[p];
    end
  end

  // R10: software interrupt byte never reads back nonzero
  a_r10_swint_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == SWINT_ADDR) |-> (rd_data == '0));
  // R9: pending bytes carry a single bit
  a_r9_pend_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (r_region == REGION_PEND) |-> (rd_data[DATA_W-1:1] == '0));
endmodule

// File: rtl/irq_sense_unit.sv
module irq_sense_unit
  import irqs_pkg::*;
#(
  parameter int unsigned        NUM_SRC    = 16,
  parameter int unsigned        PIN_BASE   = 8,
  parameter int unsigned        NUM_PINS   = 8,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = 16'h0104
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               wr_en,
  input  logic [7:0]         wr_addr,
  input  logic [7:0]         wr_data,
  input  logic [7:0]         rd_addr,
  output logic [7:0]         rd_data,
  output logic [NUM_SRC-1:0] pending,
  output logic               event_pulse,
  output logic               swint_pulse
);
  localparam int unsigned PIN_END = PIN_BASE + NUM_PINS;

  logic [NUM_SRC-1:0]       src_s;
  logic [NUM_SRC-1:0]       clr_vec;
  logic [NUM_SRC-1:0]       fire_vec;
  logic [NUM_PINS-1:0][1:0] pin_mode;

  irqs_sync #(.WIDTH(NUM_SRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(src_in), .synced(src_s)
  );

  irqs_regs #(
    .NUM_SRC(NUM_SRC), .PIN_BASE(PIN_BASE), .NUM_PINS(NUM_PINS),
    .LEVEL_MASK(LEVEL_MASK)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .pending(pending),
    .rd_data(rd_data), .pin_mode(pin_mode), .clr_vec(clr_vec),
    .swint_pulse(swint_pulse)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    sense_t mode_i;
    if (i >= PIN_BASE && i < PIN_END) begin : g_pin
      assign mode_i = sense_t'(pin_mode[i-PIN_BASE]);
    end else begin : g_fixed
      assign mode_i = LEVEL_MASK[i] ? SENSE_LEVEL : SENSE_RISE;
    end
    irqs_detect u_det (
      .clk(clk), .rst_n(rst_n), .line_s(src_s[i]), .mode(mode_i),
      .clr_req(clr_vec[i]), .pending(pending[i]), .fire(fire_vec[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) event_pulse <= 1'b0;
    else        event_pulse <= |fire_vec;
  end

  // R11: an event pulse always comes with at least one flag set
  a_r11_event_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    event_pulse |-> (pending != '0));
endmodule

// File: tb/irq_sense_unit_tb.sv
module irq_sense_unit_tb;
  localparam int NUM_SRC = 16;
  localparam int SRC_T   = 9;   // pin 1, starts rising
  localparam int PIN_T   = 1;

  logic clk = 0;
  logic rst_n = 0;
  logic [NUM_SRC-1:0] src_in = '0;
  logic wr_en = 0;
  logic [7:0] wr_addr = 0, wr_data = 0, rd_addr = 0;
  logic [7:0] rd_data;
  logic [NUM_SRC-1:0] pending;
  logic event_pulse, swint_pulse;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  irq_sense_unit u_dut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .pending(pending), .event_pulse(event_pulse),
    .swint_pulse(swint_pulse)
  );

  // vector: mode[5:4] line[3] exp_pend[2] do_clr[1] exp_after[0]
  localparam int NVEC = 12;
  localparam logic [5:0] VEC [NVEC] = '{
    {2'd2, 1'b1, 1'b1, 1'b1, 1'b0},  // R3 rise sets, clear
    {2'd2, 1'b0, 1'b0, 1'b0, 1'b0},  // R3 fall ignored
    {2'd1, 1'b1, 1'b0, 1'b0, 1'b0},  // R4 rise ignored
    {2'd1, 1'b0, 1'b1, 1'b1, 1'b0},  // R4 fall sets, clear
    {2'd3, 1'b1, 1'b1, 1'b1, 1'b0},  // R5 rise
    {2'd3, 1'b0, 1'b1, 1'b1, 1'b0},  // R5 fall
    {2'd0, 1'b1, 1'b1, 1'b1, 1'b1},  // R6 level high, clear ignored
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b0},  // R6 level low drops
    {2'd2, 1'b1, 1'b1, 1'b0, 1'b1},  // R3
    {2'd0, 1'b1, 1'b1, 1'b1, 1'b1},  // R6 held high
    {2'd2, 1'b1, 1'b1, 1'b1, 1'b0},  // R7 flag kept in edge mode, cleared
    {2'd2, 1'b1, 1'b0, 1'b0, 1'b0}   // R3 no edge, stays clear
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_addr = 0; wr_data = 0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    // R1 reset state
    chk("R1 pending", pending, 0);
    chk("R1 event", event_pulse, 0);
    chk("R1 swint", swint_pulse, 0);
    rd_addr = 8'h40; #1 chk("R1 pin0 level", rd_data, 8'h00);
    rd_addr = 8'h41; #1 chk("R1 pin1 rise", rd_data, 8'h08);

    // table walk on source 9
    for (int v = 0; v < NVEC; v++) begin
      logic [5:0] e;
      e = VEC[v];
      wr(8'h40 + PIN_T, {4'h0, e[5:4], 2'b00});
      src_in[SRC_T] = e[3];
      tick(3);
      chk($sformatf("R3-6 vec%0d pend", v), pending[SRC_T], e[2]);
      if (e[1]) begin
        wr(8'(SRC_T), 8'h00);
        chk($sformatf("R7 vec%0d after clear", v), pending[SRC_T], e[0]);
      end
    end

    // R2 latency and R11 event pulse (source 3, fixed rising)
    src_in[3] = 1;
    tick(2);
    chk("R2 not yet", pending[3], 0);
    chk("R11 not yet", event_pulse, 0);
    tick(1);
    chk("R2 set at third edge", pending[3], 1);
    chk("R11 event", event_pulse, 1);
    tick(1);
    chk("R11 one cycle", event_pulse, 0);
    rd_addr = 8'h03; #1 chk("R9 readback", rd_data, 8'h01);
    // R7 nonzero write no effect
    wr(8'h03, 8'h01);
    chk("R7 nonzero write", pending[3], 1);
    wr(8'h03, 8'h00);
    chk("R7 zero write clears", pending[3], 0);

    // R6 fixed level source 2
    src_in[2] = 1; tick(3);
    chk("R6 fixed level set", pending[2], 1);
    wr(8'h02, 8'h00);
    chk("R6 clear ignored", pending[2], 1);
    src_in[2] = 0; tick(3);
    chk("R6 drop", pending[2], 0);

    // R8 config readback masks other bits, maps to source 10
    wr(8'h42, 8'hFF);
    rd_addr = 8'h42; #1 chk("R8 readback", rd_data, 8'h0C);
    src_in[10] = 1; tick(3);
    chk("R8 both rise", pending[10], 1);
    wr(8'h0A, 8'h00);
    src_in[10] = 0; tick(3);
    chk("R8 both fall", pending[10], 1);

    // R10 software interrupt
    wr_en = 1; wr_addr = 8'h80; wr_data = 8'h01;
    @(negedge clk);
    wr_en = 0; wr_addr = 0; wr_data = 0;
    chk("R10 pulse", swint_pulse, 1);
    tick(1);
    chk("R10 one cycle", swint_pulse, 0);
    wr(8'h80, 8'h02);
    chk("R10 bit0 clear no pulse", swint_pulse, 0);
    rd_addr = 8'h80; #1 chk("R10 reads zero", rd_data, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule